// File: doc/BRIEF.md
# Carry-Linked Shift and Rotate Unit

This block is the shift and rotate slice of a small 8-bit processor datapath. It receives an operation code, a width select, an operand and the current condition flags. It returns the shifted operand together with updated negative, zero, overflow and carry flags. Every operation moves the carry flag through the operand's ends, so a chain of these operations can shift a value that spans several bytes. The bit that leaves the operand always lands in carry. For rotates, the old carry enters the vacated end, which makes each rotate a 9-bit ring.

A byte form exists for every operation. A 16-bit double-accumulator form exists only for the left shift and the logical right shift. The left shift covers both the arithmetic and the logical left shift with one encoding. An operation that is not defined at the requested width passes the operand and the flags through unchanged and raises an illegal-operation output. The unit's outputs are captured in one register stage.

Top module: `sru_shift_rotate`

## Requirements
- R1: Opcode 0 (left shift, used for both arithmetic and logical left shift) moves the operand left by one bit at either width. A 0 enters the LSB, and the old MSB (bit 7 for a byte, bit 15 for a word) goes to carry.
- R2: Opcode 2 (logical right shift) moves the operand right by one bit at either width. A 0 enters the MSB, and the old bit 0 goes to carry.
- R3: Opcode 1 (arithmetic right shift) works on bytes only. It moves bits 7..1 down by one, keeps bit 7 at its original value, and puts the old bit 0 in carry.
- R4: Opcode 3 (rotate left) works on bytes only. The old carry enters bit 0, and the old bit 7 goes to carry.
- R5: Opcode 4 (rotate right) works on bytes only. The old carry enters bit 7, and the old bit 0 goes to carry.
- R6: On a legal operation, N equals the result MSB (bit 7 for a byte, bit 15 for a word). Z is 1 exactly when the result is zero over the selected width.
- R7: On a legal operation, V equals N XOR C, both taken from the new flags.
- R8: On a legal byte operation (wide_i = 0), result bits 15..8 are 0, and operand bits 15..8 have no effect on any output.
- R9: The following combinations are illegal: opcodes 5, 6 and 7 at either width, and opcodes 1, 3 and 4 with wide_i = 1. An illegal combination sets illegal_o = 1, makes the result equal to operand_i, and makes flags_o equal to flags_i. Every legal combination gives illegal_o = 0.
- R10: The flags are packed as {N, Z, V, C} in bits 3..0, and carry-in is flags_i bit 0. Outputs show the result for the inputs present at the previous rising clock edge. While rst is high, all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code (0 shl, 1 sar, 2 shr, 3 rol, 4 ror) |
| wide_i | input | 1 | 1 selects the 16-bit double form |
| operand_i | input | 16 | Operand; bits 7..0 used for byte forms |
| flags_i | input | 4 | Current flags {N, Z, V, C} |
| result_o | output | 16 | Shifted or rotated result |
| flags_o | output | 4 | Updated flags {N, Z, V, C} |
| illegal_o | output | 1 | Operation/width combination not defined |

## Verification
On every clock cycle, the assertions check these properties:
- An illegal combination returns the previous cycle's operand and flags.
- N and Z track the result at the selected width, and V equals N XOR C.
- A byte result has a cleared upper byte.
- The arithmetic right shift keeps the sign bit.
- Rotate left places the old carry in bit 0.

Only the bench's sweeps can show that the full data movement is correct for every opcode. They apply every byte operand with every flag pattern, plus a spread of word operands. They also show that the right bit value enters each vacated end, and that carry chains across the two widths as specified.

// File: rtl/sru_pkg.sv
package sru_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        OP_SHL  = 3'd0,
        OP_SHRA = 3'd1,
        OP_SHRL = 3'd2,
        OP_ROTL = 3'd3,
        OP_ROTR = 3'd4,
        OP_RSV5 = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } shift_op_e;

    typedef enum logic [1:0] {
        FILL_ZERO  = 2'd0,
        FILL_CARRY = 2'd1,
        FILL_SIGN  = 2'd2
    } fill_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef struct packed {
        logic  legal;
        logic  dir_right;
        fill_e fill;
    } shift_ctl_t;

    // Only left shift and logical right shift have a double-width form.
    function automatic logic wide_allowed(shift_op_e op);
        return (op == OP_SHL) || (op == OP_SHRL);
    endfunction

    function automatic shift_ctl_t decode_op(shift_op_e op, logic wide);
        shift_ctl_t ctl;
        ctl.legal     = 1'b1;
        ctl.dir_right = 1'b0;
        ctl.fill      = FILL_ZERO;
        case (op)
            OP_SHL:  ctl.fill = FILL_ZERO;
            OP_SHRA: begin
                ctl.dir_right = 1'b1;
                ctl.fill      = FILL_SIGN;
            end
            OP_SHRL: ctl.dir_right = 1'b1;
            OP_ROTL: ctl.fill = FILL_CARRY;
            OP_ROTR: begin
                ctl.dir_right = 1'b1;
                ctl.fill      = FILL_CARRY;
            end
            default: ctl.legal = 1'b0;
        endcase
        if (wide && !wide_allowed(op)) begin
            ctl.legal = 1'b0;
        end
        return ctl;
    endfunction

endpackage

// File: rtl/sru_op_decode.sv
module sru_op_decode
    import sru_pkg::*;
(
    input  logic       [2:0] op_i,
    input  logic             wide_i,
    output shift_ctl_t       ctl_o
);

    always_comb begin
        ctl_o = decode_op(shift_op_e'(op_i), wide_i);
    end

endmodule

// File: rtl/sru_lane.sv
module sru_lane
    import sru_pkg::*;
#(
    parameter int W = 8
) (
    input  logic       [W-1:0] a_i,
    input  shift_ctl_t         ctl_i,
    input  logic               cin_i,
    output logic       [W-1:0] res_o,
    output logic               cout_o
);

    logic fill_bit;

    always_comb begin
        case (ctl_i.fill)
            FILL_CARRY: fill_bit = cin_i;
            FILL_SIGN:  fill_bit = a_i[W-1];
            default:    fill_bit = 1'b0;
        endcase
    end

    always_comb begin
        if (ctl_i.dir_right) begin
            res_o  = {fill_bit, a_i[W-1:1]};
            cout_o = a_i[0];
        end else begin
            res_o  = {a_i[W-2:0], fill_bit};
            cout_o = a_i[W-1];
        end
    end

endmodule

// File: rtl/sru_flag_gen.sv
module sru_flag_gen
    import sru_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [2*W-1:0] res_i,
    input  logic           wide_i,
    input  logic           cout_i,
    output ccr_t           flags_o
);

    logic msb;
    logic is_zero;

    always_comb begin
        if (wide_i) begin
            msb     = res_i[2*W-1];
            is_zero = (res_i == '0);
        end else begin
            msb     = res_i[W-1];
            is_zero = (res_i[W-1:0] == '0);
        end
        flags_o.n = msb;
        flags_o.z = is_zero;
        flags_o.c = cout_i;
        flags_o.v = msb ^ cout_i;
    end

endmodule

// File: rtl/sru_shift_rotate.sv
module sru_shift_rotate
    import sru_pkg::*;
#(
    parameter int DATA_W  = BYTE_W,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          op_i,
    input  logic                wide_i,
    input  logic [2*DATA_W-1:0] operand_i,
    input  logic [3:0]          flags_i,
    output logic [2*DATA_W-1:0] result_o,
    output logic [3:0]          flags_o,
    output logic                illegal_o
);

    localparam int DBL_W = 2 * DATA_W;

    shift_ctl_t         ctl;
    ccr_t               flags_in;
    logic [DATA_W-1:0]  narrow_res;
    logic               narrow_c;
    logic [DBL_W-1:0]   wide_res;
    logic               wide_c;
    logic [DBL_W-1:0]   sel_res;
    logic               sel_c;
    ccr_t               gen_flags;
    logic [DBL_W-1:0]   next_res;
    ccr_t               next_flags;
    logic               next_illegal;

    assign flags_in = ccr_t'(flags_i);

    sru_op_decode u_decode (
        .op_i   (op_i),
        .wide_i (wide_i),
        .ctl_o  (ctl)
    );

    sru_lane #(.W(DATA_W)) u_lane_byte (
        .a_i    (operand_i[DATA_W-1:0]),
        .ctl_i  (ctl),
        .cin_i  (flags_in.c),
        .res_o  (narrow_res),
        .cout_o (narrow_c)
    );

    sru_lane #(.W(DBL_W)) u_lane_word (
        .a_i    (operand_i),
        .ctl_i  (ctl),
        .cin_i  (flags_in.c),
        .res_o  (wide_res),
        .cout_o (wide_c)
    );

    always_comb begin
        if (wide_i) begin
            sel_res = wide_res;
            sel_c   = wide_c;
        end else begin
            sel_res = {{DATA_W{1'b0}}, narrow_res};
            sel_c   = narrow_c;
        end
    end

    sru_flag_gen #(.W(DATA_W)) u_flags (
        .res_i   (sel_res),
        .wide_i  (wide_i),
        .cout_i  (sel_c),
        .flags_o (gen_flags)
    );

    always_comb begin
        if (ctl.legal) begin
            next_res     = sel_res;
            next_flags   = gen_flags;
            next_illegal = 1'b0;
        end else begin
            next_res     = operand_i;
            next_flags   = flags_in;
            next_illegal = 1'b1;
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            logic armed_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    result_o  <= '0;
                    flags_o   <= '0;
                    illegal_o <= 1'b0;
                    armed_q   <= 1'b0;
                end else begin
                    result_o  <= next_res;
                    flags_o   <= next_flags;
                    illegal_o <= next_illegal;
                    armed_q   <= 1'b1;
                end
            end

            assert_illegal_pass_R9: assert property (@(posedge clk) disable iff (rst)
                (armed_q && illegal_o) |->
                    (result_o == $past(operand_i) && flags_o == $past(flags_i)));

            assert_nz_track_R6: assert property (@(posedge clk) disable iff (rst)
                (armed_q && !illegal_o) |->
                    (flags_o[3] == ($past(wide_i) ? result_o[DBL_W-1] : result_o[DATA_W-1]) &&
                     flags_o[2] == ($past(wide_i) ? (result_o == '0)
                                                  : (result_o[DATA_W-1:0] == '0))));

            assert_v_parity_R7: assert property (@(posedge clk) disable iff (rst)
                (armed_q && !illegal_o) |-> (flags_o[1] == (flags_o[3] ^ flags_o[0])));

            assert_hi_clear_R8: assert property (@(posedge clk) disable iff (rst)
                (armed_q && !illegal_o && !$past(wide_i)) |->
                    (result_o[DBL_W-1:DATA_W] == '0));

            assert_sign_keep_R3: assert property (@(posedge clk) disable iff (rst)
                (armed_q && !illegal_o && $past(op_i) == 3'(OP_SHRA)) |->
                    (result_o[DATA_W-1] == $past(operand_i[DATA_W-1]) &&
                     flags_o[0] == $past(operand_i[0])));

            assert_rotl_ring_R4: assert property (@(posedge clk) disable iff (rst)
                (armed_q && !illegal_o && $past(op_i) == 3'(OP_ROTL)) |->
                    (result_o[0] == $past(flags_i[0]) &&
                     flags_o[0] == $past(operand_i[DATA_W-1])));
        end else begin : g_comb
            always_comb begin
                result_o  = next_res;
                flags_o   = next_flags;
                illegal_o = next_illegal;
            end
        end
    endgenerate

endmodule

// File: tb/sru_shift_rotate_tb.sv
module sru_shift_rotate_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_i = '0;
    logic        wide_i = 1'b0;
    logic [15:0] operand_i = '0;
    logic [3:0]  flags_i = '0;
    logic [15:0] result_o;
    logic [3:0]  flags_o;
    logic        illegal_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    sru_shift_rotate u_dut (
        .clk       (clk),
        .rst       (rst),
        .op_i      (op_i),
        .wide_i    (wide_i),
        .operand_i (operand_i),
        .flags_i   (flags_i),
        .result_o  (result_o),
        .flags_o   (flags_o),
        .illegal_o (illegal_o)
    );

    // Arithmetic reference model built from the requirements.
    function automatic void model(input int op, input bit wide, input int a, input int f,
                                  output int r, output int fo, output bit ill);
        int mod, half, x, cin, c, n, z;
        bit legal;
        legal = (op == 0) || (op == 2) || (!wide && op <= 4);
        if (!legal) begin
            r = a; fo = f; ill = 1'b1;
            return;
        end
        ill  = 1'b0;
        mod  = wide ? 65536 : 256;
        half = mod / 2;
        x    = a % mod;
        cin  = f % 2;
        c    = 0;
        r    = 0;
        case (op)
            0: begin r = (x * 2) % mod;        c = (x >= half) ? 1 : 0; end
            1: begin r = x / 2 + (x & half);   c = x % 2; end
            2: begin r = x / 2;                c = x % 2; end
            3: begin r = (x * 2) % mod + cin;  c = (x >= half) ? 1 : 0; end
            default: begin r = x / 2 + cin * half; c = x % 2; end
        endcase
        n  = (r >= half) ? 1 : 0;
        z  = (r == 0) ? 1 : 0;
        fo = n * 8 + z * 4 + (n ^ c) * 2 + c;
    endfunction

    function automatic string op_tag(int op);
        case (op)
            0: return "R1";
            1: return "R3";
            2: return "R2";
            3: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic apply(input int op, input bit wide, input int a, input int f);
        int  er, ef;
        bit  ei;
        string tag;
        @(negedge clk);
        op_i      = 3'(op);
        wide_i    = wide;
        operand_i = 16'(a);
        flags_i   = 4'(f);
        model(op, wide, a, f, er, ef, ei);
        @(negedge clk);
        n_checks++;
        if (result_o !== 16'(er) || flags_o !== 4'(ef) || illegal_o !== ei) begin
            if (ei || illegal_o)                               tag = "R9";
            else if (!wide && result_o[15:8] !== 8'h00)        tag = "R8";
            else if (result_o !== 16'(er))                     tag = op_tag(op);
            else if (flags_o[3:2] !== 2'(ef / 4))              tag = "R6";
            else if (flags_o[1] !== 1'((ef / 2) % 2))          tag = "R7";
            else                                               tag = op_tag(op);
            n_fail++;
            $display("FAIL %s op=%0d wide=%0d a=%h f=%h: got res=%h flg=%h ill=%0d exp res=%h flg=%h ill=%0d",
                     tag, op, wide, a, f, result_o, flags_o, illegal_o, er[15:0], ef[3:0], ei);
        end
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        n_checks++;
        if (result_o !== 16'h0 || flags_o !== 4'h0 || illegal_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 reset state: got res=%h flg=%h ill=%0d exp res=0000 flg=0 ill=0",
                     result_o, flags_o, illegal_o);
        end
        rst = 1'b0;

        // Byte forms: every operand and flag pattern for all eight opcodes; upper byte varies (R8).
        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int f = 0; f < 16; f++) begin
                    apply(op, 1'b0, (((a * 37 + f * 11 + op) % 256) << 8) | a, f);
                end
            end
        end

        // Word forms: spread of operands, carry and N/Z inputs.
        for (int op = 0; op < 8; op++) begin
            for (int k = 0; k < 1024; k++) begin
                for (int f = 0; f < 4; f++) begin
                    apply(op, 1'b1, (k * 64 + k / 16 + f * 7) % 65536, f * 5);
                end
            end
        end

        // Word boundaries: all zeros, all ones, single MSB, single LSB.
        apply(0, 1'b1, 16'h8000, 0);
        apply(2, 1'b1, 16'h0001, 1);
        apply(0, 1'b1, 16'hFFFF, 1);
        apply(2, 1'b1, 16'h0000, 1);
        apply(3, 1'b1, 16'h1234, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule